// File: doc/BRIEF.md
# Color Lookup Table with Sequenced Component Loading

This block holds a 256-entry color table that a pixel pipeline uses to turn an 8-bit pixel code into a 24-bit red/green/blue value. Software fills the table through a small synchronous register interface. It has two word registers, one that selects an entry and one that accepts color components.

Filling an entry takes one write to the selector register, then three writes to the component register. The first component write lands in the red channel, the second in green and the third in blue. After the blue write the selected entry advances by one, wrapping from 255 to 0, so a run of entries can be loaded with a single selector write followed by a stream of component writes. Each component and each entry number is taken from the most significant byte of the 32-bit bus word, and the lower bytes are ignored.

The lookup side is a registered read port. A request with a pixel code returns that entry's color one clock later, together with a valid flag.

Top module: `pal_dac`

## Requirements
- R1: While reset is asserted, and after it is released, every table entry reads black (0x000000) except entry 255, which reads white (0xFFFFFF). The selected entry and the component phase both start at zero (red), and `px_valid` and `px_rgb` are zero.
- R2: A write to byte offset 0 sets the selected entry to `bus_wdata[31:24]`. It also returns the phase to red, even when a red or green component has already been written.
- R3: Successive writes to byte offset 4 store `bus_wdata[31:24]` into red, then green, then blue of the selected entry. The lookup result is packed as {red[23:16], green[15:8], blue[7:0]}, and the low 24 bits of the bus word have no effect.
- R4: After the blue write, the selected entry increments modulo 256 (255 goes to 0) and the phase returns to red.
- R5: A write to any offset other than 0 and 4 changes no table entry, no selected entry and no phase.
- R6: `bus_rdata` is zero in every cycle.
- R7: When `px_req` is high at a clock edge, `px_rgb` takes the color of entry `px_index` at that edge and `px_valid` goes high. When `px_req` is low, `px_valid` goes low and `px_rgb` holds its value.
- R8: A component write becomes visible to lookups issued from the next edge onward. A lookup of the same entry at the same edge returns the value the entry held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data; the top byte is used |
| bus_rdata | output | 32 | Read data, always zero |
| px_req | input | 1 | Lookup request |
| px_index | input | 8 | Pixel code to translate |
| px_valid | output | 1 | Lookup result valid, one cycle after the request |
| px_rgb | output | 24 | Looked-up color {R,G,B} |

## Verification
The checker watches the write sequencer on every cycle. It confirms that a selector write loads the top byte and resets the phase, that each component write advances the phase, that the entry number wraps after blue, and that writes to stray offsets leave both untouched. The same checker also covers zero read data and the latency and hold behaviour of the lookup flag and data. Only the bench scenarios can show the actual table contents: the reset colors, the byte placement inside an entry, the old-value result of a lookup issued on the same edge as a write, and the fact that stray writes leave entries unchanged.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int COMP_W = 8;
  localparam int IDX_W  = 8;

  typedef struct packed {
    logic [COMP_W-1:0] red;
    logic [COMP_W-1:0] grn;
    logic [COMP_W-1:0] blu;
  } rgb_t;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BUS_W     = 32,
  parameter int SEL_OFS   = 0,
  parameter int COMP_OFS  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic                comp_we,
  output phase_e              comp_sel,
  output logic [COMP_W-1:0]   comp_val,
  output logic [IDX_W-1:0]    cur_idx,
  output phase_e              cur_phase
);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_OFS);
  localparam logic [ADDR_W-1:0] COMP_A = ADDR_W'(COMP_OFS);

  logic             sel_hit;
  logic             comp_hit;
  logic [IDX_W-1:0] idx_q, idx_d;
  phase_e           ph_q, ph_d;
  logic             seq_en;

  assign sel_hit  = bus_we && (bus_addr == SEL_A);
  assign comp_hit = bus_we && (bus_addr == COMP_A);
  assign seq_en   = sel_hit || comp_hit;

  always_comb begin
    idx_d = idx_q;
    ph_d  = ph_q;
    if (sel_hit) begin
      idx_d = bus_wdata[BUS_W-1 -: IDX_W];
      ph_d  = PH_RED;
    end else if (comp_hit) begin
      unique case (ph_q)
        PH_RED:  ph_d = PH_GRN;
        PH_GRN:  ph_d = PH_BLU;
        PH_BLU: begin
          ph_d  = PH_RED;
          idx_d = idx_q + 1'b1;
        end
        default: ph_d = PH_RED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= PH_RED;
    end else if (seq_en) begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
    end
  end

  assign comp_we   = comp_hit;
  assign comp_sel  = ph_q;
  assign comp_val  = bus_wdata[BUS_W-1 -: COMP_W];
  assign cur_idx   = idx_q;
  assign cur_phase = ph_q;
endmodule

// File: rtl/pal_table.sv
module pal_table
  import pal_pkg::*;
#(
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_we,
  input  phase_e            comp_sel,
  input  logic [COMP_W-1:0] comp_val,
  input  logic [IDX_W-1:0]  wr_idx,
  output rgb_t              entries [DEPTH]
);
  localparam int   WHITE_IDX = DEPTH - 1;
  localparam rgb_t BLACK     = '0;
  localparam rgb_t WHITE     = '1;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam rgb_t RST_VAL = (e == WHITE_IDX) ? WHITE : BLACK;
    logic hit;
    rgb_t ent_d;

    assign hit = comp_we && (wr_idx == IDX_W'(e));

    always_comb begin
      ent_d = entries[e];
      unique case (comp_sel)
        PH_RED:  ent_d.red = comp_val;
        PH_GRN:  ent_d.grn = comp_val;
        PH_BLU:  ent_d.blu = comp_val;
        default: ent_d = entries[e];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entries[e] <= RST_VAL;
      else if (hit) entries[e] <= ent_d;
    end
  end
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_pkg::*;
#(
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [IDX_W-1:0] idx,
  input  rgb_t             entries [DEPTH],
  output logic             valid,
  output rgb_t             rgb
);
  rgb_t sel_d;

  assign sel_d = entries[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rgb <= '0;
    else if (req) rgb <= sel_d;
  end
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BUS_W    = 32,
  parameter int SEL_OFS  = 0,
  parameter int COMP_OFS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic                  px_req,
  input  logic [IDX_W-1:0]      px_index,
  output logic                  px_valid,
  output logic [3*COMP_W-1:0]   px_rgb
);
  localparam int DEPTH = 1 << IDX_W;

  logic              comp_we;
  phase_e            comp_sel;
  logic [COMP_W-1:0] comp_val;
  logic [IDX_W-1:0]  cur_idx;
  phase_e            cur_phase;
  rgb_t              entries [DEPTH];
  rgb_t              look_rgb;

  pal_seq #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .SEL_OFS(SEL_OFS), .COMP_OFS(COMP_OFS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .comp_we(comp_we), .comp_sel(comp_sel),
    .comp_val(comp_val), .cur_idx(cur_idx), .cur_phase(cur_phase)
  );

  pal_table #(.DEPTH(DEPTH)) u_tab (
    .clk(clk), .rst_n(rst_n), .comp_we(comp_we), .comp_sel(comp_sel),
    .comp_val(comp_val), .wr_idx(cur_idx), .entries(entries)
  );

  pal_lookup #(.DEPTH(DEPTH)) u_look (
    .clk(clk), .rst_n(rst_n), .req(px_req), .idx(px_index),
    .entries(entries), .valid(px_valid), .rgb(look_rgb)
  );

  assign px_rgb    = look_rgb;
  assign bus_rdata = '0;
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
  import pal_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BUS_W    = 32,
  parameter int SEL_OFS  = 0,
  parameter int COMP_OFS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [BUS_W-1:0]    bus_wdata,
  input logic [BUS_W-1:0]    bus_rdata,
  input logic                px_req,
  input logic                px_valid,
  input logic [3*COMP_W-1:0] px_rgb,
  input logic [IDX_W-1:0]    cur_idx,
  input phase_e              cur_phase
);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_OFS);
  localparam logic [ADDR_W-1:0] COMP_A = ADDR_W'(COMP_OFS);

  logic             sel_w, comp_w, stray_w;
  logic [IDX_W-1:0] idx_inc;

  assign sel_w   = bus_we && (bus_addr == SEL_A);
  assign comp_w  = bus_we && (bus_addr == COMP_A);
  assign stray_w = bus_we && !sel_w && !comp_w;
  assign idx_inc = cur_idx + 1'b1;

  assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_w |=> (cur_idx == $past(bus_wdata[BUS_W-1 -: IDX_W])) && (cur_phase == PH_RED));

  assert_phase_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_w && cur_phase == PH_RED) |=> (cur_phase == PH_GRN) && $stable(cur_idx));

  assert_phase_grn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_w && cur_phase == PH_GRN) |=> (cur_phase == PH_BLU) && $stable(cur_idx));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_w && cur_phase == PH_BLU) |=> (cur_idx == $past(idx_inc)) && (cur_phase == PH_RED));

  assert_stray_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stray_w |=> $stable(cur_idx) && $stable(cur_phase));

  assert_rdata_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata == '0);

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    px_req |=> px_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !px_req |=> !px_valid && $stable(px_rgb));
endmodule

bind pal_dac pal_dac_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .SEL_OFS(SEL_OFS), .COMP_OFS(COMP_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .px_req(px_req),
  .px_valid(px_valid), .px_rgb(px_rgb), .cur_idx(cur_idx),
  .cur_phase(cur_phase)
);

// File: tb/pal_dac_test.sv
`timescale 1ns/1ps
module pal_dac_test;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        px_req;
  logic [7:0]  px_index;
  logic        px_valid;
  logic [23:0] px_rgb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pal_dac uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .px_req(px_req),
    .px_index(px_index), .px_valid(px_valid), .px_rgb(px_rgb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        look;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [23:0] expv;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h0, 32'h10FF_FFFF, 24'h0},
    '{1'b0, 4'h4, 32'h11AB_CDEF, 24'h0},
    '{1'b0, 4'h4, 32'h2201_0203, 24'h0},
    '{1'b0, 4'h4, 32'h33FF_FFFF, 24'h0},
    '{1'b1, 4'h0, 32'h1000_0000, 24'h112233},
    '{1'b0, 4'h4, 32'h4400_0000, 24'h0},
    '{1'b0, 4'h4, 32'h5500_0000, 24'h0},
    '{1'b0, 4'h4, 32'h6600_0000, 24'h0},
    '{1'b1, 4'h0, 32'h1100_0000, 24'h445566},
    '{1'b1, 4'h0, 32'h1000_0000, 24'h112233},
    '{1'b0, 4'h0, 32'hFF00_0000, 24'h0},
    '{1'b0, 4'h4, 32'hAA00_0000, 24'h0},
    '{1'b0, 4'h4, 32'hBB00_0000, 24'h0},
    '{1'b0, 4'h4, 32'hCC00_0000, 24'h0},
    '{1'b0, 4'h4, 32'h0100_0000, 24'h0},
    '{1'b0, 4'h4, 32'h0200_0000, 24'h0},
    '{1'b0, 4'h4, 32'h0300_0000, 24'h0},
    '{1'b1, 4'h0, 32'hFF00_0000, 24'hAABBCC},
    '{1'b1, 4'h0, 32'h0000_0000, 24'h010203}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic look(input logic [7:0] i, input logic [23:0] exp, input string req);
    @(negedge clk);
    px_req = 1'b1; px_index = i;
    @(negedge clk);
    px_req = 1'b0;
    chk(req, {31'd0, px_valid}, 32'd1);
    chk(req, {8'd0, px_rgb}, {8'd0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    px_req = 1'b0; px_index = '0;
    do_reset();

    // R1: reset state at the ports
    chk("R1 valid", {31'd0, px_valid}, 32'd0);
    chk("R1 rgb", {8'd0, px_rgb}, 32'd0);
    look(8'd255, 24'hFFFFFF, "R1 white");
    look(8'd5, 24'h000000, "R1 black");
    look(8'd254, 24'h000000, "R1 black254");

    // R2 R3 R4: vector table walk
    for (int k = 0; k < NV; k++) begin
      if (VECS[k].look) look(VECS[k].data[31:24], VECS[k].expv, "R3/R4 vec");
      else              wr(VECS[k].addr, VECS[k].data);
    end

    // R6: read data while a write is in progress
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h2000_0000;
    chk("R6 rdata", bus_rdata, 32'd0);
    @(negedge clk);
    bus_we = 1'b0;

    // R5: stray writes between components
    wr(4'h4, 32'h7700_0000);
    wr(4'h8, 32'h9900_0000);
    wr(4'hC, 32'h3000_0000);
    wr(4'h1, 32'h5500_0000);
    wr(4'h4, 32'h8800_0000);
    wr(4'h4, 32'h9900_0000);
    look(8'h20, 24'h778899, "R5 sequence kept");
    look(8'h30, 24'h000000, "R5 entry untouched");
    wr(4'h4, 32'hE100_0000);
    wr(4'h4, 32'hE200_0000);
    wr(4'h4, 32'hE300_0000);
    look(8'h21, 24'hE1E2E3, "R5 index kept");

    // R2: selector write mid-triplet resets phase to red
    wr(4'h0, 32'h4000_0000);
    wr(4'h4, 32'hA100_0000);
    wr(4'h0, 32'h4000_0000);
    wr(4'h4, 32'hB200_0000);
    look(8'h40, 24'hB20000, "R2 phase reset");

    // R8: lookup on the same edge as the blue write
    wr(4'h0, 32'h5000_0000);
    wr(4'h4, 32'h1000_0000);
    wr(4'h4, 32'h2000_0000);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h3000_0000;
    px_req = 1'b1; px_index = 8'h50;
    @(negedge clk);
    bus_we = 1'b0; px_req = 1'b0;
    chk("R8 old value", {8'd0, px_rgb}, 32'h0010_2000);
    look(8'h50, 24'h102030, "R8 new value");

    // R7: no request -> valid drops, data held
    @(negedge clk);
    px_index = 8'hFF;
    @(negedge clk);
    chk("R7 valid low", {31'd0, px_valid}, 32'd0);
    chk("R7 hold", {8'd0, px_rgb}, 32'h0010_2030);

    // R1: reset again restores the table
    do_reset();
    chk("R1 valid after reset", {31'd0, px_valid}, 32'd0);
    look(8'h10, 24'h000000, "R1 cleared");
    look(8'hFF, 24'hFFFFFF, "R1 white restored");
    wr(4'h4, 32'h5A00_0000);
    wr(4'h4, 32'h5B00_0000);
    wr(4'h4, 32'h5C00_0000);
    look(8'h00, 24'h5A5B5C, "R1 index/phase zero");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule